// File: doc/BRIEF.md
# Sleep-Pin Power-Mode Controller

This block decides when a pseudo-static memory drops into a low-power state and when it returns. One active-low sleep pin drives both paths. A bit in the configuration register picks which low-power state the pin selects. With the bit set, the memory keeps refreshing part of the array and comes back at once when the pin rises. With the bit clear, the memory enters deep power-down. In that state all refresh stops and the contents are lost, and leaving it costs a long initialization period before accesses are served again.

Entry is deliberate. The pin must stay low for a programmable number of clock cycles before the mode changes, and a shorter low pulse is discarded. The same pin also opens a window for reprogramming the configuration register. After the pin falls, the first write cycle on the chip-enable and write-enable strobes loads the register from the address bus, latched as soon as either strobe rises. A low period used for such a load does not also lead to low-power entry. The dwell time and the initialization time are parameters given in clock cycles.

Top module: `slp_mode_ctrl`

## Requirements
- R1: In standby, the mode leaves standby at the clock edge that samples the pin low for the DWELL_CYC-th consecutive time. After DWELL_CYC-1 such edges the mode is still standby.
- R2: The mode output codes are 0 standby, 1 partial-refresh sleep, 2 deep power-down and 3 initialization. On entry, the mode becomes 1 when bit 4 of the configuration register is 1, and 2 when that bit is 0.
- R3: In modes 1, 2 and 3, `blocked_o` is 1 and `ready_o` is 0 whatever `req_i` is. In standby, `blocked_o` is 0 and `ready_o` equals `req_i`.
- R4: In mode 1, the first edge that samples the pin high returns the mode to standby.
- R5: `refresh_en_o` is 0 exactly while the mode is 2, and 1 in every other mode.
- R6: In mode 2, the first edge that samples the pin high moves the mode to 3. The mode then stays 3 for INIT_CYC edges, ignoring the pin, and becomes standby at the INIT_CYC-th edge.
- R7: A write is an edge that samples `ce_n_i` and `we_n_i` both low. The first write after a falling edge of the pin in standby loads `cfg_o` from `addr_i`. The load happens at the first later edge that samples either strobe high while the pin is still low.
- R8: Only one load happens per low period of the pin. A write while the pin is high leaves `cfg_o` unchanged.
- R9: After reset, `cfg_o` holds 0x000010 and the mode is standby. Outside standby, `cfg_o` never changes.
- R10: A low pulse on the pin shorter than DWELL_CYC edges leaves the mode at standby. The count starts again from zero at the next fall.
- R11: After a load, no low-power entry happens until the pin has returned high. A fresh low period then needs the full dwell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_n_i | input | 1 | Active-low sleep pin |
| ce_n_i | input | 1 | Active-low chip enable |
| we_n_i | input | 1 | Active-low write enable |
| addr_i | input | ADDR_W | Address bus, source of register loads |
| req_i | input | 1 | Read/write access request |
| mode_o | output | 2 | Current mode (code as in R2) |
| blocked_o | output | 1 | Accesses are being ignored |
| refresh_en_o | output | 1 | Refresh may run |
| ready_o | output | 1 | The request in this cycle is served |
| cfg_o | output | ADDR_W | Configuration register value |

## Verification
The mode changes one edge after the qualifying pin sample: after the DWELL_CYC-th low sample, after the first high sample in modes 1 and 2, and after the INIT_CYC-th edge in mode 3. A register load shows on `cfg_o` one edge after the strobe rise. `blocked_o`, `ready_o` and `refresh_en_o` follow the mode with no further delay, and `ready_o` follows `req_i` combinationally. The bench drives and samples on the falling clock edge and counts rising edges explicitly. It checks one edge before each mode change that nothing has moved yet, and again at the edge where the change is due.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    MODE_STBY = 2'd0,
    MODE_PAR  = 2'd1,
    MODE_DPD  = 2'd2,
    MODE_INIT = 2'd3
  } slp_mode_e;

  // True on the edge that completes a run of lim counted cycles.
  function automatic logic last_tick(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) == lim;
  endfunction

  // Low-power target chosen by the retention-select bit.
  function automatic slp_mode_e sleep_target(input logic keep_part);
    return keep_part ? MODE_PAR : MODE_DPD;
  endfunction

endpackage

// File: rtl/slp_pin_watch.sv
module slp_pin_watch #(
  parameter int DWELL_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic sleep_n_i,
  input  logic hold_i,
  input  logic clr_i,
  output logic fall_o,
  output logic expire_o
);
  import slp_pkg::*;

  localparam int CW = $clog2(DWELL_CYC + 1);

  logic          sleep_q;
  logic [CW-1:0] cnt_q;
  logic          counting;

  assign counting = en_i & ~sleep_n_i & ~hold_i & ~clr_i;
  assign fall_o   = sleep_q & ~sleep_n_i;
  assign expire_o = counting & last_tick(32'(cnt_q), 32'(DWELL_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sleep_q <= sleep_n_i;
      if (!counting || expire_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/slp_cfg_load.sv
module slp_cfg_load #(
  parameter int                ADDR_W  = 22,
  parameter logic [ADDR_W-1:0] CFG_RST = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              sleep_n_i,
  input  logic              fall_i,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] cfg_o,
  output logic              load_o,
  output logic              consumed_o
);

  logic              armed_q;
  logic              wr_q;
  logic              consumed_q;
  logic [ADDR_W-1:0] cfg_q;

  assign load_o     = en_i & ~sleep_n_i & armed_q & wr_q & (ce_n_i | we_n_i);
  assign cfg_o      = cfg_q;
  assign consumed_o = consumed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      wr_q       <= 1'b0;
      consumed_q <= 1'b0;
      cfg_q      <= CFG_RST;
    end else begin
      wr_q <= ~ce_n_i & ~we_n_i;
      if (!en_i || sleep_n_i || load_o) armed_q <= 1'b0;
      else if (fall_i)                  armed_q <= 1'b1;
      if (sleep_n_i)   consumed_q <= 1'b0;
      else if (load_o) consumed_q <= 1'b1;
      if (load_o) cfg_q <= addr_i;
    end
  end

endmodule

// File: rtl/slp_init_timer.sv
module slp_init_timer #(
  parameter int INIT_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  import slp_pkg::*;

  localparam int CW = $clog2(INIT_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i & last_tick(32'(cnt_q), 32'(INIT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i || done_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/slp_mode_ctrl.sv
module slp_mode_ctrl #(
  parameter int                ADDR_W    = 22,
  parameter int                DWELL_CYC = 16,
  parameter int                INIT_CYC  = 40,
  parameter int                SLEEP_BIT = 4,
  parameter logic [ADDR_W-1:0] CFG_RST   = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_n_i,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              req_i,
  output logic [1:0]        mode_o,
  output logic              blocked_o,
  output logic              refresh_en_o,
  output logic              ready_o,
  output logic [ADDR_W-1:0] cfg_o
);
  import slp_pkg::*;

  slp_mode_e mode_q, mode_d;

  // Named internal events, visible to the bound checker.
  logic in_stby;
  logic pin_fall;
  logic dwell_expire;
  logic load_stb;
  logic load_consumed;
  logic init_done;

  assign in_stby = (mode_q == MODE_STBY);

  slp_pin_watch #(.DWELL_CYC(DWELL_CYC)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (in_stby),
    .sleep_n_i(sleep_n_i),
    .hold_i   (load_consumed),
    .clr_i    (load_stb),
    .fall_o   (pin_fall),
    .expire_o (dwell_expire)
  );

  slp_cfg_load #(.ADDR_W(ADDR_W), .CFG_RST(CFG_RST)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (in_stby),
    .sleep_n_i (sleep_n_i),
    .fall_i    (pin_fall),
    .ce_n_i    (ce_n_i),
    .we_n_i    (we_n_i),
    .addr_i    (addr_i),
    .cfg_o     (cfg_o),
    .load_o    (load_stb),
    .consumed_o(load_consumed)
  );

  slp_init_timer #(.INIT_CYC(INIT_CYC)) u_init (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (mode_q == MODE_INIT),
    .done_o(init_done)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_STBY: if (dwell_expire) mode_d = sleep_target(cfg_o[SLEEP_BIT]);
      MODE_PAR:  if (sleep_n_i)    mode_d = MODE_STBY;
      MODE_DPD:  if (sleep_n_i)    mode_d = MODE_INIT;
      MODE_INIT: if (init_done)    mode_d = MODE_STBY;
      default:                     mode_d = MODE_STBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_STBY;
    else        mode_q <= mode_d;
  end

  assign mode_o       = mode_q;
  assign blocked_o    = ~in_stby;
  assign ready_o      = req_i & in_stby;
  assign refresh_en_o = (mode_q != MODE_DPD);

endmodule

// File: rtl/slp_mode_ctrl_chk.sv
module slp_mode_ctrl_chk #(
  parameter int ADDR_W    = 22,
  parameter int SLEEP_BIT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_n_i,
  input logic [1:0]        mode_o,
  input logic              blocked_o,
  input logic              ready_o,
  input logic              refresh_en_o,
  input logic [ADDR_W-1:0] cfg_o,
  input logic              dwell_expire,
  input logic              load_stb,
  input logic              load_consumed,
  input logic              init_done
);

  p_glitch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !dwell_expire) |=> mode_o == 2'd0);

  p_enter_par_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && dwell_expire && cfg_o[SLEEP_BIT]) |=> mode_o == 2'd1);

  p_enter_dpd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && dwell_expire && !cfg_o[SLEEP_BIT]) |=> mode_o == 2'd2);

  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_o |-> !ready_o);

  p_par_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && sleep_n_i) |=> mode_o == 2'd0);

  p_dpd_norefresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && dwell_expire && !cfg_o[SLEEP_BIT]) |=> !refresh_en_o);

  p_dpd_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && sleep_n_i) |=> mode_o == 2'd3);

  p_init_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3 && !init_done) |=> mode_o == 2'd3);

  p_load_stby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> mode_o == 2'd0);

  p_no_load_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_n_i |=> $stable(cfg_o));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0) |=> $stable(cfg_o));

  p_consume_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_consumed |-> !dwell_expire);

endmodule

bind slp_mode_ctrl slp_mode_ctrl_chk #(.ADDR_W(ADDR_W), .SLEEP_BIT(SLEEP_BIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_n_i    (sleep_n_i),
  .mode_o       (mode_o),
  .blocked_o    (blocked_o),
  .ready_o      (ready_o),
  .refresh_en_o (refresh_en_o),
  .cfg_o        (cfg_o),
  .dwell_expire (dwell_expire),
  .load_stb     (load_stb),
  .load_consumed(load_consumed),
  .init_done    (init_done)
);

// File: tb/slp_mode_ctrl_tb.sv
module slp_mode_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int AW    = 22;
  localparam int DW    = 16;
  localparam int IC    = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_n = 1'b1;
  logic          ce_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          req = 1'b0;
  logic [1:0]    mode;
  logic          blocked, refresh_en, ready;
  logic [AW-1:0] cfg;

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  slp_mode_ctrl #(.ADDR_W(AW), .DWELL_CYC(DW), .INIT_CYC(IC)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_n_i   (sleep_n),
    .ce_n_i      (ce_n),
    .we_n_i      (we_n),
    .addr_i      (addr),
    .req_i       (req),
    .mode_o      (mode),
    .blocked_o   (blocked),
    .refresh_en_o(refresh_en),
    .ready_o     (ready),
    .cfg_o       (cfg)
  );

  // Bench model: sleep target from the retention bit (bit 4).
  function automatic logic [1:0] exp_target(input logic [AW-1:0] c);
    return c[4] ? 2'd1 : 2'd2;
  endfunction

  function automatic logic exp_ready(input logic [1:0] m, input logic r);
    return (m == 2'd0) ? r : 1'b0;
  endfunction

  function automatic logic exp_refresh(input logic [1:0] m);
    return (m == 2'd2) ? 1'b0 : 1'b1;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Open a low period, perform one write cycle, leave the pin low.
  task automatic load_cfg(input logic [AW-1:0] val);
    sleep_n = 1'b0; cyc(1);
    ce_n = 1'b0; we_n = 1'b0; addr = val; cyc(1);
    we_n = 1'b1; cyc(1);
    chk("R7 load value", 32'(cfg), 32'(val));
    ce_n = 1'b1; cyc(1);
  endtask

  task automatic enter_and_check(input logic [AW-1:0] c, input logic r);
    sleep_n = 1'b0; cyc(DW - 1);
    chk("R1 still standby before dwell", 32'(mode), 32'd0);
    req = r; cyc(1);
    chk("R2 target mode", 32'(mode), 32'(exp_target(c)));
    chk("R3 ready in low power", 32'(ready), 32'(exp_ready(mode, r)));
    chk("R3 blocked in low power", 32'(blocked), 32'd1);
    chk("R5 refresh in low power", 32'(refresh_en), 32'(exp_refresh(exp_target(c))));
  endtask

  task automatic leave_and_check(input logic [AW-1:0] c);
    sleep_n = 1'b1; cyc(1);
    if (exp_target(c) == 2'd1) begin
      chk("R4 partial exit", 32'(mode), 32'd0);
    end else begin
      chk("R6 init start", 32'(mode), 32'd3);
      chk("R5 refresh back on", 32'(refresh_en), 32'd1);
      cyc(IC - 1);
      chk("R6 init still running", 32'(mode), 32'd3);
      cyc(1);
      chk("R6 init done", 32'(mode), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] old_cfg;
    logic [AW-1:0] val;
    void'($urandom(32'd2718));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R9 reset cfg", 32'(cfg), 32'h10);
    chk("R9 reset mode", 32'(mode), 32'd0);
    chk("R5 reset refresh", 32'(refresh_en), 32'd1);
    chk("R3 reset blocked", 32'(blocked), 32'd0);
    req = 1'b1; cyc(1);
    chk("R3 standby ready", 32'(ready), 32'd1);
    req = 1'b0; cyc(1);
    chk("R3 standby idle", 32'(ready), 32'd0);

    // R8: write with the pin high is ignored.
    ce_n = 1'b0; we_n = 1'b0; addr = 22'h3ABCDE; cyc(1);
    we_n = 1'b1; cyc(1); ce_n = 1'b1; cyc(1);
    chk("R8 write with pin high", 32'(cfg), 32'h10);

    // R10: random short glitches never enter low power.
    for (int i = 0; i < 20; i++) begin
      int len;
      len = 1 + int'($urandom % (DW - 1));
      sleep_n = 1'b0; cyc(len);
      sleep_n = 1'b1; cyc(1);
      chk("R10 glitch no entry", 32'(mode), 32'd0);
    end

    // Default cfg (bit 4 = 1): partial-refresh sleep, R9 write ignored there.
    enter_and_check(22'h10, 1'b1);
    ce_n = 1'b0; we_n = 1'b0; addr = 22'h000000; cyc(1);
    we_n = 1'b1; cyc(1); ce_n = 1'b1; cyc(1);
    chk("R9 cfg frozen in sleep", 32'(cfg), 32'h10);
    leave_and_check(22'h10);

    // R7/R8/R11: load with bit 4 clear, second write ignored, no entry.
    load_cfg(22'h2A5A0F);
    ce_n = 1'b0; we_n = 1'b0; addr = 22'h155555; cyc(1);
    we_n = 1'b1; cyc(1); ce_n = 1'b1; cyc(1);
    chk("R8 second write ignored", 32'(cfg), 32'h2A5A0F);
    cyc(DW + 4);
    chk("R11 no entry after load", 32'(mode), 32'd0);
    sleep_n = 1'b1; cyc(1);

    // Deep power-down, then the pin toggles during init and is ignored.
    enter_and_check(22'h2A5A0F, 1'b0);
    cyc(5);
    chk("R5 refresh off in deep", 32'(refresh_en), 32'd0);
    sleep_n = 1'b1; cyc(1);
    chk("R6 init entered", 32'(mode), 32'd3);
    sleep_n = 1'b0; cyc(3); sleep_n = 1'b1; cyc(IC - 4);
    chk("R6 pin ignored in init", 32'(mode), 32'd3);
    old_cfg = cfg;
    cyc(1);
    chk("R6 standby after init", 32'(mode), 32'd0);
    chk("R9 cfg kept over init", 32'(cfg), 32'(old_cfg));

    // Random loads and entries.
    for (int i = 0; i < 8; i++) begin
      val = AW'($urandom);
      load_cfg(val);
      cyc(DW + 2);
      chk("R11 load consumes low period", 32'(mode), 32'd0);
      sleep_n = 1'b1; cyc(1);
      enter_and_check(val, 1'($urandom));
      leave_and_check(val);
      req = 1'b0;
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule